// File: doc/BRIEF.md
# Fast Trapezoidal Trigger Filter

This block turns a stream of ADC codes into a fast trapezoidal shaping signal and flags the events it finds in that signal. Each 8 ns clock delivers a group of raw samples, four by default and eight when the build parameter asks for it. A front stage adds the group into one working sample. If the input pulses are negative, the stage negates the sum, so that an event always appears as a positive step.

The shaper subtracts two equal-length box sums of the working stream: a leading box over the newest `rise_len` samples and a trailing box over `rise_len` samples that ends `span_len` clocks back. Both boxes are kept as running sums fed from one shared delay line, so the cost per clock does not depend on the programmed lengths. A comparator with hysteresis emits a single-cycle trigger when the shaped value climbs from below the threshold to the threshold or above. Inconsistent length settings raise a configuration-error flag and block triggers. A channel-enable input gates the trigger only.

Top module: `fast_trig_filter`

## Requirements
- R1: The working sample is the sum of LANES unsigned raw samples, where lane i occupies bits [i*SAMP_W +: SAMP_W] of `samples`.
- R2: With `pos_pol`=1 the working sample is the lane sum. With `pos_pol`=0 it is the negated lane sum, so downward pulses on a high baseline produce a positive filter response.
- R3: `filt_out` seen after clock edge n equals the sum of working samples x[m-i] minus the sum of x[m-span_len-i], for i = 0..rise_len-1, where m is the sample presented two edges earlier. Samples before reset count as zero.
- R4: Both lengths work over the whole range 1..127, including `rise_len` = `span_len` = 1 and `rise_len` = `span_len` = 127.
- R5: A constant input level, including a large negative-polarity baseline, contributes nothing to `filt_out` once `rise_len`+`span_len` clocks have passed.
- R6: `trig_out` is high for exactly one cycle, in the cycle after the first `filt_out` value at or above `thresh` that follows a value below it. A long flat top yields one trigger.
- R7: After a trigger, no further trigger occurs until `filt_out` has been below `thresh`. A second separated pulse triggers again.
- R8: A `filt_out` value equal to `thresh` counts as reaching it.
- R9: `cfg_err` is 1 when `span_len` < `rise_len` or when `rise_len` = 0, and 0 otherwise. While it is 1 no trigger is produced, but `filt_out` keeps following R3.
- R10: With `chan_en`=0, `trig_out` stays low while `filt_out` keeps following R3.
- R11: Reset clears `filt_out` and `trig_out` and leaves the comparator disarmed. A threshold at or below the post-reset value of zero does not fire until the filter has first been below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | processing clock, one working sample per edge |
| rst_n | input | 1 | asynchronous active-low reset |
| chan_en | input | 1 | channel enable; 0 holds the trigger low |
| pos_pol | input | 1 | 1 = positive input pulses, 0 = negative |
| rise_len | input | 7 | box length in clocks |
| span_len | input | 7 | rise plus gap length in clocks |
| thresh | input | 25 | signed trigger threshold |
| samples | input | LANES*SAMP_W (56) | raw samples arriving in one clock |
| filt_out | output | 25 | signed shaped value |
| trig_out | output | 1 | single-cycle trigger pulse |
| cfg_err | output | 1 | length settings inconsistent |

## Verification
The bench keeps its own sample history and compares the shaped value with a direct box-sum formula on every cycle. An off-by-one delay-line tap, a lane left out of the sum, or a lost sign on the negative-polarity path would all show up as per-cycle miscompares and wrong peaks. Several trigger cases stress the comparator: a peak exactly equal to the threshold, a long flat top, two separated pulses, and the dip and return of the negative lobe with a threshold of zero. A design that compared strictly, retriggered without re-arming, or came out of reset armed would give the wrong trigger count. Disabled and misconfigured runs check that the trigger is blocked while the filter keeps running, and the length extremes of 1 and 127 reach both ends of the delay line.

// File: rtl/ftf_pkg.sv
package ftf_pkg;
    localparam int LEN_W    = 7;
    localparam int LEN_MAX  = (1 << LEN_W) - 1;
    localparam int TAP_W    = LEN_W + 1;
    localparam int DL_DEPTH = 2 * LEN_MAX;

    function automatic logic lengths_bad(input logic [LEN_W-1:0] rise,
                                         input logic [LEN_W-1:0] span);
        return (rise == '0) || (span < rise);
    endfunction
endpackage

// File: rtl/ftf_lane_sum.sv
module ftf_lane_sum #(
    parameter int LANES  = 4,
    parameter int SAMP_W = 14,
    parameter int XW     = 17
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pos_pol,
    input  logic [LANES*SAMP_W-1:0]  raw,
    output logic signed [XW-1:0]     x_q
);
    logic [SAMP_W-1:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = raw[g*SAMP_W +: SAMP_W];
    end

    typedef struct packed {
        logic signed [XW-1:0] x;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic signed [XW-1:0] acc;
        acc = '0;
        for (int i = 0; i < LANES; i++) begin
            acc = acc + $signed({{(XW-SAMP_W){1'b0}}, lane[i]});
        end
        st_d.x = pos_pol ? acc : -acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign x_q = st_q.x;

    AST_POS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        pos_pol |=> (x_q >= 0)); // R2
endmodule

// File: rtl/ftf_trap_core.sv
module ftf_trap_core #(
    parameter int XW = 17,
    parameter int AW = 24,
    parameter int FW = 25
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic signed [XW-1:0]           x_in,
    input  logic [ftf_pkg::LEN_W-1:0]      rise,
    input  logic [ftf_pkg::LEN_W-1:0]      span,
    output logic signed [FW-1:0]           filt
);
    localparam int DEPTH = ftf_pkg::DL_DEPTH;
    localparam int TW    = ftf_pkg::TAP_W;

    typedef struct packed {
        logic [DEPTH-1:0][XW-1:0] dl;
        logic signed [AW-1:0]     lead;
        logic signed [AW-1:0]     trail;
    } st_t;

    st_t st_d, st_q;

    function automatic logic signed [XW-1:0] tap(input st_t s,
                                                 input logic [TW-1:0] k,
                                                 input logic signed [XW-1:0] cur);
        if (k == '0) return cur;
        return $signed(s.dl[k - 1'b1]);
    endfunction

    always_comb begin
        logic [TW-1:0] k_rise, k_span, k_far;
        k_rise = {1'b0, rise};
        k_span = {1'b0, span};
        k_far  = k_span + k_rise;
        st_d.dl    = {st_q.dl[DEPTH-2:0], x_in};
        st_d.lead  = st_q.lead + AW'(x_in) - AW'(tap(st_q, k_rise, x_in));
        st_d.trail = st_q.trail + AW'(tap(st_q, k_span, x_in))
                                - AW'(tap(st_q, k_far, x_in));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt = FW'(st_q.lead) - FW'(st_q.trail);

    AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rise == '0 && span == '0) |=> $stable(filt)); // R9
endmodule

// File: rtl/ftf_cross_detect.sv
module ftf_cross_detect #(
    parameter int FW = 25
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [FW-1:0] filt,
    input  logic signed [FW-1:0] thresh,
    input  logic                 en,
    input  logic                 block,
    output logic                 trig
);
    typedef struct packed {
        logic trig;
        logic armed;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.armed = (filt < thresh);
        st_d.trig  = en && !block && st_q.armed && (filt >= thresh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trig = st_q.trig;

    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig); // R6
    AST_TRIG_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> $past(filt >= thresh)); // R8
    AST_TRIG_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !trig); // R10
    AST_TRIG_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        block |=> !trig); // R9
endmodule

// File: rtl/fast_trig_filter.sv
module fast_trig_filter #(
    parameter int LANES  = 4,
    parameter int SAMP_W = 14,
    localparam int XW    = SAMP_W + $clog2(LANES) + 1,
    localparam int AW    = XW + ftf_pkg::LEN_W,
    localparam int FW    = AW + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          chan_en,
    input  logic                          pos_pol,
    input  logic [ftf_pkg::LEN_W-1:0]     rise_len,
    input  logic [ftf_pkg::LEN_W-1:0]     span_len,
    input  logic signed [FW-1:0]          thresh,
    input  logic [LANES*SAMP_W-1:0]       samples,
    output logic signed [FW-1:0]          filt_out,
    output logic                          trig_out,
    output logic                          cfg_err
);
    logic signed [XW-1:0] x_w;

    assign cfg_err = ftf_pkg::lengths_bad(rise_len, span_len);

    ftf_lane_sum #(.LANES(LANES), .SAMP_W(SAMP_W), .XW(XW)) u_sum (
        .clk(clk), .rst_n(rst_n), .pos_pol(pos_pol), .raw(samples), .x_q(x_w)
    );

    ftf_trap_core #(.XW(XW), .AW(AW), .FW(FW)) u_core (
        .clk(clk), .rst_n(rst_n), .x_in(x_w), .rise(rise_len), .span(span_len),
        .filt(filt_out)
    );

    ftf_cross_detect #(.FW(FW)) u_cross (
        .clk(clk), .rst_n(rst_n), .filt(filt_out), .thresh(thresh),
        .en(chan_en), .block(cfg_err), .trig(trig_out)
    );
endmodule

// File: tb/sim_fast_trig_filter.sv
module sim_fast_trig_filter;
    localparam int LANES = 4, SAMP_W = 14, LEN_W = 7, FW = 25;
    localparam int SETTLE = 260, TAIL = 300, HMAX = 2048;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, chan_en, pos_pol, trig_out, cfg_err;
    logic [LEN_W-1:0] rise_len, span_len;
    logic signed [FW-1:0] thresh, filt_out;
    logic [LANES*SAMP_W-1:0] samples;

    fast_trig_filter #(.LANES(LANES), .SAMP_W(SAMP_W)) u0 (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .pos_pol(pos_pol),
        .rise_len(rise_len), .span_len(span_len), .thresh(thresh),
        .samples(samples), .filt_out(filt_out), .trig_out(trig_out), .cfg_err(cfg_err)
    );

    int n_vec = 0, n_bad = 0;
    longint xh [HMAX];
    longint fh [HMAX];

    typedef struct packed {
        int req; int en; int pol; int rise; int span; int thr;
        int base; int amp; int dur; int gap; int peak; int ntrig; int err;
    } vec_t;

    // req, en, pol, rise, span, thr, base, amp, dur, gap, peak, ntrig, err
    localparam vec_t VECS [12] = '{
        '{3, 1, 1,   4,   6,  100,    0,  5,  10,   0,  200, 1, 0},  // R3 R1
        '{3, 1, 1,   8,   8, 1000,    0,  3,  20,   0,  240, 0, 0},  // R3 below threshold
        '{2, 1, 0,   5,   9,  300, 2000, 20,   3,   0,  600, 1, 0},  // R2 negative pulses
        '{4, 1, 1,   1,   1,   50,    0,  7,   1,   0,   70, 1, 0},  // R4 minimum lengths
        '{4, 1, 1, 127, 127, 1000,    0,  1, 200,   0, 1270, 1, 0},  // R4 maximum lengths
        '{5, 1, 0,  16,  40, 2000, 8000, 15,  50,   0, 2400, 1, 0},  // R5 baseline cancels
        '{7, 1, 1,  10,  20,  500,    0,  5,  10, 100,  500, 2, 0},  // R7 re-arm, two pulses
        '{8, 1, 1,  10,  10,  500,    0,  5,  10,   0,  500, 1, 0},  // R8 peak equals threshold
        '{6, 1, 1,   6,  60,  100,    0,  4,  80,   0,  240, 1, 0},  // R6 long flat top
        '{10, 0, 1,  4,   6,  100,    0,  5,  10,   0,  200, 0, 0},  // R10 disabled
        '{9, 1, 1,  10,   5,  100,    0,  5,  10,   0,   -1, 0, 1},  // R9 span below rise
        '{11, 1, 1,  4,   6,    0,    0,  5,  10,   0,  200, 1, 0}   // R11 zero threshold
    };

    task automatic check(input string rq, input string what, input longint act, input longint exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic longint xv(input int j);
        return (j < 0) ? 0 : xh[j];
    endfunction

    function automatic longint model_f(input int k, input int rl, input int sl);
        longint acc;
        int m;
        acc = 0;
        m = k - 2;
        for (int i = 0; i < rl; i++) acc += xv(m - i) - xv(m - sl - i);
        return acc;
    endfunction

    task automatic run_case(input vec_t v);
        string rq;
        int total, mism_f, mism_t, ntrig, lv;
        longint fm, peak, fa, fe, ta, te, xs;
        bit inp, tx;
        rq = $sformatf("R%0d", v.req);
        mism_f = 0; mism_t = 0; ntrig = 0; fa = 0; fe = 0; ta = 0; te = 0;
        rst_n = 1'b0;
        chan_en = v.en[0];
        pos_pol = v.pol[0];
        rise_len = v.rise[LEN_W-1:0];
        span_len = v.span[LEN_W-1:0];
        thresh = FW'(v.thr);
        samples = '0;
        repeat (3) @(negedge clk);
        check(rq, "cfg_err", longint'(cfg_err), longint'(v.err));
        rst_n = 1'b1;
        total = SETTLE + 2 * v.dur + v.gap + TAIL;
        peak = -(64'sd1 <<< 40);
        for (int k = 0; k < total; k++) begin
            fm = model_f(k, v.rise, v.span);
            fh[k] = fm;
            if (longint'(filt_out) !== fm) begin
                if (mism_f == 0) begin fa = longint'(filt_out); fe = fm; end
                mism_f++;
            end
            tx = (v.en != 0) && (v.err == 0) && (k >= 2) &&
                 (fh[k-1] >= v.thr) && (fh[k-2] < v.thr);
            if (trig_out !== tx) begin
                if (mism_t == 0) begin ta = longint'(trig_out); te = longint'(tx); end
                mism_t++;
            end
            if (longint'(filt_out) > peak) peak = longint'(filt_out);
            if (trig_out) ntrig++;
            inp = (k >= SETTLE && k < SETTLE + v.dur) ||
                  (v.gap > 0 && k >= SETTLE + v.dur + v.gap &&
                   k < SETTLE + 2 * v.dur + v.gap);
            xs = 0;
            for (int i = 0; i < LANES; i++) begin
                lv = v.pol != 0 ? v.base + (inp ? v.amp * (i + 1) : 0)
                                : v.base - (inp ? v.amp * (i + 1) : 0);
                samples[i*SAMP_W +: SAMP_W] = lv[SAMP_W-1:0];
                xs += lv;
            end
            xh[k] = (v.pol != 0) ? xs : -xs;
            @(negedge clk);
        end
        check(rq, "filter per cycle (R3)", fa, fe);
        check(rq, "trigger per cycle (R6)", ta, te);
        if (v.peak >= 0) check(rq, "peak", peak, longint'(v.peak));
        check(rq, "trigger count", longint'(ntrig), longint'(v.ntrig));
    endtask

    initial begin
        rst_n = 1'b0; chan_en = 1'b1; pos_pol = 1'b1; rise_len = 7'd4; span_len = 7'd6;
        thresh = 25'sd100; samples = '0;
        for (int i = 0; i < 12; i++) run_case(VECS[i]);

        // R11: reset holds outputs clear even while large samples arrive
        rst_n = 1'b0;
        samples = {LANES{14'd9000}};
        thresh = -25'sd5;
        repeat (2) @(negedge clk);
        check("R11", "filt in reset", longint'(filt_out), 0);
        check("R11", "trig in reset", longint'(trig_out), 0);

        // R9 and R4: configuration error decode at the ports
        rise_len = 7'd0;   span_len = 7'd10;
        #1 check("R9", "cfg_err rise zero", longint'(cfg_err), 1);
        rise_len = 7'd127; span_len = 7'd127;
        #1 check("R4", "cfg_err equal max", longint'(cfg_err), 0);
        rise_len = 7'd20;  span_len = 7'd19;
        #1 check("R9", "cfg_err span one short", longint'(cfg_err), 1);
        rise_len = 7'd1;   span_len = 7'd127;
        #1 check("R4", "cfg_err widest gap", longint'(cfg_err), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog (R1..R11 run): actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule